// File: doc/BRIEF.md
# Multiplexed GPIO Port Register Bank

This block is the register bank for a group of general-purpose I/O ports. There are up to 32 pins per port. Every pin has four settings: a three-bit function code, a data bit, a two-bit drive-strength code and a two-bit pull code. Each port also has one four-bit I/O bias code. A simple 32-bit register bus reaches all of these settings. Writes take effect at the clock edge. Read data is combinational from the address.

The function code picks who owns the pad:
- Code 0 makes the pin an input.
- Code 1 makes it an output driven from the stored data bit.
- Any other code gives the pad to a peripheral, which supplies its own output value and output enable.

Pad inputs pass through a two-flop synchronizer. A read of the data register returns the stored bit for output pins and the synchronized pad level for all other pins. The drive, pull and bias codes are only exported as control outputs for the pad ring.

Port p occupies 0x24 bytes starting at p*0x24:
- four function registers at offsets 0x00, 0x04, 0x08 and 0x0C;
- the data register at 0x10;
- two drive registers at 0x14 and 0x18;
- two pull registers at 0x1C and 0x20.

The port's bias register sits separately at 0x300 + 4*p.

Top module: `gpio_mux_bank`

## Requirements
- R1: In function register j of a port (offset 4*j), bits 4i+2..4i hold the function code of pin 8j+i. Bit 4i+3 is not stored and reads as 0, so writing all ones reads back 0x77777777.
- R2: A pin with function 0 has pad_oe low. A pin with function 1 has pad_oe high and pad_out equal to its data bit. A pin with any function of 2 to 7 takes pad_out and pad_oe from alt_dout and alt_oe of the same pin. Flat pin index p*32+n is pin n of port p.
- R3: Writing the data register (offset 0x10) stores all 32 bits. On a read, bit n returns the stored bit when pin n has function 1, and otherwise the pad level seen through two flops. A pad change made just after a clock edge is not visible in a read sampled after the next edge, and is visible after the one following.
- R4: In drive register j (offset 0x14 + 4*j), bits 2i+1..2i hold the drive code of pin 16j+i. Code k stands for 10*(k+1) mA. The code appears on drv_code[2*(p*32+n)+:2].
- R5: In pull register j (offset 0x1C + 4*j), bits 2i+1..2i hold the pull code of pin 16j+i. Code 0 means no pull, 1 pull-up, 2 pull-down, and code 3 is stored and read back as written. The code appears on pull_code[2*(p*32+n)+:2].
- R6: The bias register of port p (address 0x300 + 4*p) stores the low 4 bits of a write, reads its upper 28 bits as 0, and drives bias_code[4*p+:4]. The codes 0x0, 0x6, 0x9, 0xA and 0xD stand for 1.8, 2.5, 2.8, 3.0 and 3.3 V.
- R7: After reset, every function, data, drive, pull and bias field is 0, and all pad_oe bits are low.
- R8: A read of an unmapped address returns 0, and a write to one changes no register. Unmapped addresses are those not word aligned, those above the last port, and bias slots of ports that do not exist.
- R9: A write changes only the addressed register of the addressed port. When bus_we is low, no drive, pull or bias code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | NUM_PORTS*32 | Raw pad input levels |
| alt_dout | input | NUM_PORTS*32 | Peripheral output value per pin |
| alt_oe | input | NUM_PORTS*32 | Peripheral output enable per pin |
| pad_out | output | NUM_PORTS*32 | Pad output value |
| pad_oe | output | NUM_PORTS*32 | Pad output enable |
| drv_code | output | NUM_PORTS*64 | Drive-strength code, 2 bits per pin |
| pull_code | output | NUM_PORTS*64 | Pull code, 2 bits per pin |
| bias_code | output | NUM_PORTS*4 | I/O bias code per port |

## Verification
The assertions take for granted that bus_addr, bus_we and bus_wdata are steady across each rising edge. They also assume pad_in changes only between edges, so that the two-cycle synchronizer relation with the raw pads holds exactly. The stimulus meets both conditions by changing every input on the falling edge. It holds each bus access for one full cycle, and it releases reset on a falling edge.

// File: rtl/gpiobank_pkg.sv
package gpiobank_pkg;

  localparam int PORT_PINS   = 32;
  localparam int PORT_STRIDE = 36;      // 0x24 bytes per port
  localparam int BIAS_BASE   = 768;     // 0x300
  localparam int PORT_W      = 5;
  localparam int FUNC_W      = 3;
  localparam int CODE_W      = 2;
  localparam int BIAS_W      = 4;

  typedef enum logic [2:0] {
    RK_NONE  = 3'd0,
    RK_FUNC  = 3'd1,
    RK_DATA  = 3'd2,
    RK_DRIVE = 3'd3,
    RK_PULL  = 3'd4,
    RK_BIAS  = 3'd5
  } reg_kind_e;

  typedef struct packed {
    logic              hit;
    reg_kind_e         kind;
    logic [1:0]        sub;
    logic [PORT_W-1:0] port;
  } reg_sel_t;

  // kind of register at a word-aligned offset inside one port window
  function automatic reg_kind_e offset_kind(input logic [5:0] off);
    case (off)
      6'h00, 6'h04, 6'h08, 6'h0C: offset_kind = RK_FUNC;
      6'h10:                      offset_kind = RK_DATA;
      6'h14, 6'h18:               offset_kind = RK_DRIVE;
      6'h1C, 6'h20:               offset_kind = RK_PULL;
      default:                    offset_kind = RK_NONE;
    endcase
  endfunction

  // index of the sub-register inside its group
  function automatic logic [1:0] offset_sub(input logic [5:0] off);
    case (off)
      6'h04, 6'h18, 6'h20: offset_sub = 2'd1;
      6'h08:               offset_sub = 2'd2;
      6'h0C:               offset_sub = 2'd3;
      default:             offset_sub = 2'd0;
    endcase
  endfunction

  // bit position of a pin's function field inside its register
  function automatic int func_pos(input int pin);
    return 4 * (pin % 8);
  endfunction

  // bit position of a pin's drive or pull field inside its register
  function automatic int code_pos(input int pin);
    return 2 * (pin % 16);
  endfunction

endpackage

// File: rtl/gpiobank_addr_dec.sv
module gpiobank_addr_dec
  import gpiobank_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);

  logic [ADDR_W-1:0] rel;

  always_comb begin
    sel = '{hit: 1'b0, kind: RK_NONE, sub: 2'd0, port: '0};
    rel = '0;
    if (addr[1:0] == 2'b00) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (addr == ADDR_W'(BIAS_BASE + 4 * p)) begin
          sel.hit  = 1'b1;
          sel.kind = RK_BIAS;
          sel.port = PORT_W'(p);
        end
        if (addr >= ADDR_W'(p * PORT_STRIDE) &&
            addr <  ADDR_W'((p + 1) * PORT_STRIDE)) begin
          rel      = addr - ADDR_W'(p * PORT_STRIDE);
          sel.kind = offset_kind(rel[5:0]);
          sel.sub  = offset_sub(rel[5:0]);
          sel.hit  = (offset_kind(rel[5:0]) != RK_NONE);
          sel.port = PORT_W'(p);
        end
      end
    end
  end

endmodule

// File: rtl/gpiobank_sync.sv
module gpiobank_sync #(
  parameter int WIDTH = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gpiobank_port.sv
module gpiobank_port
  import gpiobank_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  reg_kind_e                   kind,
  input  logic [1:0]                  sub,
  input  logic [31:0]                 wdata,
  input  logic [PORT_PINS-1:0]        pad_sync,
  input  logic [PORT_PINS-1:0]        alt_dout,
  input  logic [PORT_PINS-1:0]        alt_oe,
  output logic [31:0]                 rd_word,
  output logic [PORT_PINS-1:0]        pad_out,
  output logic [PORT_PINS-1:0]        pad_oe,
  output logic [CODE_W*PORT_PINS-1:0] drv_code,
  output logic [CODE_W*PORT_PINS-1:0] pull_code,
  output logic [BIAS_W-1:0]           bias_code
);

  localparam int FUNC_PER_REG = 8;
  localparam int CODE_PER_REG = 16;

  logic [FUNC_W*PORT_PINS-1:0] func_v;
  logic [PORT_PINS-1:0]        data_rd;
  logic [BIAS_W-1:0]           bias_q;

  for (genvar i = 0; i < PORT_PINS; i++) begin : g_pin
    localparam int FREG = i / FUNC_PER_REG;
    localparam int CREG = i / CODE_PER_REG;
    localparam int FPOS = 4 * (i % FUNC_PER_REG);
    localparam int CPOS = 2 * (i % CODE_PER_REG);

    logic [FUNC_W-1:0] fsel_q;
    logic              dbit_q;
    logic [CODE_W-1:0] drv_q;
    logic [CODE_W-1:0] pull_q;
    logic              is_out;
    logic              is_alt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fsel_q <= '0;
        dbit_q <= 1'b0;
        drv_q  <= '0;
        pull_q <= '0;
      end else if (wr_en) begin
        if (kind == RK_FUNC && sub == 2'(FREG))  fsel_q <= wdata[FPOS +: FUNC_W];
        if (kind == RK_DATA)                     dbit_q <= wdata[i];
        if (kind == RK_DRIVE && sub == 2'(CREG)) drv_q  <= wdata[CPOS +: CODE_W];
        if (kind == RK_PULL && sub == 2'(CREG))  pull_q <= wdata[CPOS +: CODE_W];
      end
    end

    assign is_out = (fsel_q == 3'd1);
    assign is_alt = (fsel_q > 3'd1);

    assign pad_oe[i]  = is_alt ? alt_oe[i]   : is_out;
    assign pad_out[i] = is_alt ? alt_dout[i] : dbit_q;
    assign data_rd[i] = is_out ? dbit_q : pad_sync[i];

    assign func_v[FUNC_W*i +: FUNC_W]    = fsel_q;
    assign drv_code[CODE_W*i +: CODE_W]  = drv_q;
    assign pull_code[CODE_W*i +: CODE_W] = pull_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          bias_q <= '0;
    else if (wr_en && kind == RK_BIAS)   bias_q <= wdata[BIAS_W-1:0];
  end

  assign bias_code = bias_q;

  always_comb begin
    rd_word = '0;
    case (kind)
      RK_FUNC: begin
        for (int i = 0; i < FUNC_PER_REG; i++) begin
          if (int'(sub) * FUNC_PER_REG + i < PORT_PINS)
            rd_word[4*i +: FUNC_W] =
              func_v[FUNC_W*(int'(sub)*FUNC_PER_REG + i) +: FUNC_W];
        end
      end
      RK_DATA: rd_word[PORT_PINS-1:0] = data_rd;
      RK_DRIVE: begin
        for (int i = 0; i < CODE_PER_REG; i++) begin
          if (int'(sub) * CODE_PER_REG + i < PORT_PINS)
            rd_word[2*i +: CODE_W] =
              drv_code[CODE_W*(int'(sub)*CODE_PER_REG + i) +: CODE_W];
        end
      end
      RK_PULL: begin
        for (int i = 0; i < CODE_PER_REG; i++) begin
          if (int'(sub) * CODE_PER_REG + i < PORT_PINS)
            rd_word[2*i +: CODE_W] =
              pull_code[CODE_W*(int'(sub)*CODE_PER_REG + i) +: CODE_W];
        end
      end
      RK_BIAS: rd_word[BIAS_W-1:0] = bias_q;
      default: rd_word = '0;
    endcase
  end

endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
  import gpiobank_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 12
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic                               bus_we,
  input  logic [31:0]                        bus_wdata,
  output logic [31:0]                        bus_rdata,
  input  logic [NUM_PORTS*PORT_PINS-1:0]     pad_in,
  input  logic [NUM_PORTS*PORT_PINS-1:0]     alt_dout,
  input  logic [NUM_PORTS*PORT_PINS-1:0]     alt_oe,
  output logic [NUM_PORTS*PORT_PINS-1:0]     pad_out,
  output logic [NUM_PORTS*PORT_PINS-1:0]     pad_oe,
  output logic [NUM_PORTS*PORT_PINS*2-1:0]   drv_code,
  output logic [NUM_PORTS*PORT_PINS*2-1:0]   pull_code,
  output logic [NUM_PORTS*BIAS_W-1:0]        bias_code
);

  localparam int NPINS = NUM_PORTS * PORT_PINS;

  reg_sel_t          sel;
  logic              map_hit;
  reg_kind_e         sel_kind;
  logic [1:0]        sel_sub;
  logic [PORT_W-1:0] sel_port;
  logic [NPINS-1:0]  pad_sync;
  logic [31:0]       port_rd [NUM_PORTS];

  gpiobank_addr_dec #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W)
  ) dec_i (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign map_hit  = sel.hit;
  assign sel_kind = sel.kind;
  assign sel_sub  = sel.sub;
  assign sel_port = sel.port;

  gpiobank_sync #(
    .WIDTH (NPINS)
  ) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic wr_here;
    assign wr_here = bus_we && map_hit && (sel_port == PORT_W'(p));

    gpiobank_port port_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_here),
      .kind      (sel_kind),
      .sub       (sel_sub),
      .wdata     (bus_wdata),
      .pad_sync  (pad_sync[p*PORT_PINS +: PORT_PINS]),
      .alt_dout  (alt_dout[p*PORT_PINS +: PORT_PINS]),
      .alt_oe    (alt_oe[p*PORT_PINS +: PORT_PINS]),
      .rd_word   (port_rd[p]),
      .pad_out   (pad_out[p*PORT_PINS +: PORT_PINS]),
      .pad_oe    (pad_oe[p*PORT_PINS +: PORT_PINS]),
      .drv_code  (drv_code[p*PORT_PINS*2 +: PORT_PINS*2]),
      .pull_code (pull_code[p*PORT_PINS*2 +: PORT_PINS*2]),
      .bias_code (bias_code[p*BIAS_W +: BIAS_W])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (map_hit && sel_port == PORT_W'(p)) bus_rdata = port_rd[p];
    end
  end

endmodule

// File: rtl/gpio_mux_bank_chk.sv
module gpio_mux_bank_chk
  import gpiobank_pkg::*;
#(
  parameter int NUM_PORTS = 3
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             bus_we,
  input logic [31:0]                      bus_wdata,
  input logic                             map_hit,
  input reg_kind_e                        sel_kind,
  input logic [1:0]                       sel_sub,
  input logic [PORT_W-1:0]                sel_port,
  input logic [NUM_PORTS*PORT_PINS-1:0]   pad_in,
  input logic [NUM_PORTS*PORT_PINS-1:0]   pad_sync,
  input logic [NUM_PORTS*PORT_PINS*2-1:0] drv_code,
  input logic [NUM_PORTS*PORT_PINS*2-1:0] pull_code,
  input logic [NUM_PORTS*BIAS_W-1:0]      bias_code
);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  // R3: synchronized pads lag the raw pads by exactly two edges
  a_r3_sync_two_flops: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (pad_sync == $past(pad_in, 2)));

  // R4: a write to drive register 0 of port 0 lands on its pins' codes
  a_r4_drive_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && map_hit && sel_kind == RK_DRIVE && sel_port == '0 && sel_sub == 2'd0)
    |=> (drv_code[31:0] == $past(bus_wdata)));

  // R5: a write to pull register 1 of port 0 lands on its pins' codes
  a_r5_pull_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && map_hit && sel_kind == RK_PULL && sel_port == '0 && sel_sub == 2'd1)
    |=> (pull_code[63:32] == $past(bus_wdata)));

  // R6: port 0 bias takes the low nibble of the write
  a_r6_bias_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && map_hit && sel_kind == RK_BIAS && sel_port == '0)
    |=> (bias_code[3:0] == $past(bus_wdata[3:0])));

  // R8: a write to an unmapped address leaves every exported code alone
  a_r8_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !map_hit)
    |=> ($stable(drv_code) && $stable(pull_code) && $stable(bias_code)));

  // R9: without a write strobe no exported code moves
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we) |=> ($stable(drv_code) && $stable(pull_code) && $stable(bias_code)));

endmodule

bind gpio_mux_bank gpio_mux_bank_chk #(.NUM_PORTS(NUM_PORTS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .map_hit   (map_hit),
  .sel_kind  (sel_kind),
  .sel_sub   (sel_sub),
  .sel_port  (sel_port),
  .pad_in    (pad_in),
  .pad_sync  (pad_sync),
  .drv_code  (drv_code),
  .pull_code (pull_code),
  .bias_code (bias_code)
);

// File: tb/gpio_mux_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_mux_bank_tb_top;

  localparam int NP = 3;
  localparam int NB = NP * 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [11:0]     bus_addr = '0;
  logic            bus_we = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NB-1:0]   pad_in = '0;
  logic [NB-1:0]   alt_dout = '0;
  logic [NB-1:0]   alt_oe = '0;
  logic [NB-1:0]   pad_out;
  logic [NB-1:0]   pad_oe;
  logic [2*NB-1:0] drv_code;
  logic [2*NB-1:0] pull_code;
  logic [4*NP-1:0] bias_code;

  always #4 clk = ~clk;   // 125 MHz

  gpio_mux_bank #(.NUM_PORTS(NP), .ADDR_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .alt_dout(alt_dout), .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .drv_code(drv_code), .pull_code(pull_code), .bias_code(bias_code)
  );

  typedef struct {
    logic [11:0] addr;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  rd_item_t q[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench's own view of the register layout
  function automatic logic [31:0] func_readback(input logic [31:0] w);
    logic [31:0] r = '0;
    for (int i = 0; i < 8; i++) r[4*i +: 3] = w[4*i +: 3];
    return r;
  endfunction

  function automatic logic [31:0] data_view(input logic [31:0] out_mask,
                                            input logic [31:0] stored,
                                            input logic [31:0] pads);
    return (out_mask & stored) | (~out_mask & pads);
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: every task starts and ends on a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    bus_addr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  // monitor: pops expected reads and compares just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        rd_item_t it;
        it = q.pop_front();
        total++;
        if (bus_rdata !== it.exp) begin
          bad++;
          $display("FAIL %s addr=%h act=%h exp=%h", it.tag, it.addr, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [31:0] mask0;

  initial begin
    alt_dout[31:0] = 32'h0000_00A6;
    alt_oe[31:0]   = 32'h0000_003C;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 reset state
    check("R7 pad_oe", 128'(pad_oe), 128'd0);
    check("R7 drv_code", 128'(drv_code), 128'd0);
    check("R7 pull_code", 128'(pull_code), 128'd0);
    check("R7 bias_code", 128'(bias_code), 128'd0);
    rd(12'h000, 32'h0, "R7 func0");
    rd(12'h010, 32'h0, "R7 data");
    rd(12'h308, 32'h0, "R7 bias2");

    // R1 function fields keep only three bits
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, func_readback(32'hFFFF_FFFF), "R1 func readback");
    // R2 peripheral owns pins 0..7
    check("R2 alt oe", 128'(pad_oe[7:0]), 128'(alt_oe[7:0]));
    check("R2 alt out", 128'(pad_out[7:0]), 128'(alt_dout[7:0]));

    // R2/R3 mixed input and output pins
    pad_in[31:0] = 32'hA5A5_A5A5;
    wr(12'h000, 32'h0000_1101);       // pins 0,2,3 output, pin 1 input
    wr(12'h010, 32'h0000_000F);
    mask0 = 32'h0000_000D;
    check("R2 oe mix", 128'(pad_oe[7:0]), 128'(8'h0D));
    check("R2 out mix", 128'(pad_out[3:0]), 128'(4'hF));
    rd(12'h010, data_view(mask0, 32'h0000_000F, 32'hA5A5_A5A5), "R3 data mix");

    // R3 two-edge latency
    pad_in[31:0] = 32'h0F0F_0F00;
    rd(12'h010, data_view(mask0, 32'h0000_000F, 32'hA5A5_A5A5), "R3 old after one edge");
    rd(12'h010, data_view(mask0, 32'h0000_000F, 32'h0F0F_0F00), "R3 new after two edges");

    // R1 second function register maps pins 8..15
    wr(12'h004, 32'h1000_0000);
    check("R1 pin15 oe", 128'(pad_oe[15:8]), 128'(8'h80));
    rd(12'h004, 32'h1000_0000, "R1 func1");

    // R4 drive register 1 covers pins 16..31
    wr(12'h018, 32'h8000_0001);
    check("R4 drv hi", 128'(drv_code[63:32]), 128'(32'h8000_0001));
    check("R4 drv lo", 128'(drv_code[31:0]), 128'd0);
    rd(12'h018, 32'h8000_0001, "R4 drv readback");

    // R5 pull registers of port 1
    wr(12'h040, 32'h0000_0006);
    wr(12'h044, 32'hFFFF_FFFF);
    check("R5 pull p1 lo", 128'(pull_code[95:64]), 128'(32'h0000_0006));
    check("R5 pull p1 hi", 128'(pull_code[127:96]), 128'(32'hFFFF_FFFF));
    rd(12'h040, 32'h0000_0006, "R5 pull readback");

    // R6 bias of port 2
    wr(12'h308, 32'hFFFF_FFFD);
    rd(12'h308, 32'h0000_000D, "R6 bias readback");
    check("R6 bias out", 128'(bias_code), 128'(12'hD00));

    // R8 unmapped accesses
    wr(12'h06C, 32'hFFFF_FFFF);
    wr(12'h30C, 32'h0000_000F);
    wr(12'h302, 32'h0000_000F);
    rd(12'h06C, 32'h0, "R8 beyond ports");
    rd(12'h30C, 32'h0, "R8 bias of missing port");
    rd(12'h300, 32'h0, "R8 misaligned write ignored");
    rd(12'h302, 32'h0, "R8 misaligned read");
    rd(12'h200, 32'h0, "R8 hole");
    check("R8 bias untouched", 128'(bias_code), 128'(12'hD00));
    check("R8 drv untouched", 128'(drv_code), 128'(192'h0000_0000_8000_0001_0000_0000));

    // R9 writes to port 1 leave port 0 alone
    wr(12'h024, 32'h0000_0001);
    wr(12'h034, 32'hFFFF_FFFF);
    check("R9 p1 pin0 oe", 128'(pad_oe[63:32]), 128'(32'h0000_0001));
    check("R9 p1 pin0 out", 128'(pad_out[32]), 128'(1'b1));
    check("R9 p0 out kept", 128'(pad_out[3:0]), 128'(4'hF));
    rd(12'h034, data_view(32'h1, 32'hFFFF_FFFF, 32'h0), "R9 p1 data");
    rd(12'h010, data_view(mask0, 32'h0000_000F, 32'h0F0F_0F00), "R9 p0 data kept");

    // R7 reset in the middle of operation
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 oe after reset", 128'(pad_oe), 128'd0);
    check("R7 bias after reset", 128'(bias_code), 128'd0);
    rd(12'h018, 32'h0, "R7 drv after reset");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule